// File: doc/BRIEF.md
# SDRAM Read-Latency and Data-Mask Timing Pipeline

This block sits in the data path of an SDRAM controller, next to the command sequencer. It does not issue commands and does not generate addresses. It watches the read, write, burst-stop and precharge strobes as the sequencer issues them, and works out on which clocks data moves on the memory bus. Reads return data a programmable two or three clocks after the command. The block raises a capture strobe on exactly those clocks and gives the beat number within the burst. It also raises a flag one clock earlier, when the device starts to drive the bus. Writes need their first data on the same clock as the command, so the write drive enable follows the command with no register in between.

The two directions use the per-byte masks differently. On a write, a mask bit that is high blocks its byte on the same clock. On a read, the mask takes effect two clocks after it is presented. The block turns both into per-byte enables that the data path can use directly. It also gives a registered copy of the mask for the device pins.

A burst-stop or precharge stops the issue of further beats. Beats already in flight still arrive, so the read bus is released a CAS-latency number of clocks later. A new read or write that arrives while a burst is running replaces it on the following beat. Because every read beat goes through the same delay, beats from two reads can never collide.

Top module: `sdram_dpath_timer`

## Requirements
- R1: A read strobed in cycle c gives its first capture strobe (`rd_valid`) in cycle c+m. The latency m is taken from `cas_code` in the read's own cycle: code 3'b010 selects 2, and 3'b011 or any reserved code selects 3.
- R2: `bus_oe` is high from cycle c+m-1 up to and including the cycle of the last captured beat. It is low in every cycle in which no read beat is due in that cycle or the next.
- R3: An uninterrupted read gives exactly `burst_len` consecutive capture strobes, with `rd_beat` counting 0, 1, 2 and so on. A length of 0 is treated as 1.
- R4: A write strobed in cycle c holds `wr_drive` high in cycles c through c+`burst_len`-1, with `wr_beat` counting up from 0 starting in cycle c itself. A length of 0 is treated as 1.
- R5: In every cycle in which `wr_drive` is high, `wr_byte_en` equals the bitwise inverse of `dqm_in` in that same cycle. In every other cycle it is all zero. Bit i of each mask belongs to byte lane i.
- R6: `rd_byte_en` equals the bitwise inverse of the `dqm_in` value presented two cycles earlier in every cycle in which `rd_valid` is high, and is all zero otherwise. `dqm_q` is `dqm_in` delayed by one clock.
- R7: `term_cmd` or `pre_cmd` in cycle k stops the burst. No read beat is issued from cycle k onward, so the last capture is in cycle k+m-1 and `bus_oe` is low from cycle k+m. `wr_drive` is low from cycle k.
- R8: A read strobed one or more cycles after an earlier read starts its own beat 0 in cycle c+m. Beats of the earlier read issued before cycle c are still delivered, and no beat of the earlier read appears from cycle c+m on.
- R9: Precedence: a read strobe beats a write strobe in the same cycle, and either one beats a burst-stop or precharge. A read stops a running write from its own cycle, and a write stops further read beats from being issued from its own cycle.
- R10: While `rst_n` is low, `rd_valid`, `bus_oe`, `wr_drive`, `rd_byte_en`, `wr_byte_en` and `dqm_q` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Read strobe issued this cycle |
| wr_cmd | input | 1 | Write strobe issued this cycle |
| term_cmd | input | 1 | Burst-stop strobe issued this cycle |
| pre_cmd | input | 1 | Precharge strobe issued this cycle |
| cas_code | input | 3 | Latency code: 3'b010 selects 2, any other code selects 3 |
| burst_len | input | LEN_W | Beats per burst; 0 is treated as 1 |
| dqm_in | input | MASK_W | Per-byte mask for this cycle |
| rd_valid | output | 1 | Read data is to be captured this cycle |
| rd_beat | output | LEN_W | Index of the beat being captured |
| rd_byte_en | output | MASK_W | Byte lanes that carry read data this cycle |
| bus_oe | output | 1 | The device is predicted to drive the bus this cycle |
| wr_drive | output | 1 | Drive write data onto the bus this cycle |
| wr_beat | output | LEN_W | Index of the write beat being driven |
| wr_byte_en | output | MASK_W | Byte lanes whose write takes effect this cycle |
| dqm_q | output | MASK_W | Registered mask for the device pins |

## Verification
The bench builds the block with its default parameters: two mask lanes and a 10-bit length. The 10-bit length lets a full-page burst of 512 beats run to its last index without wrapping the counters. Two lanes are enough to show that each lane is masked on its own. With these settings the bench covers both latencies and back-to-back reads one clock apart. It also covers a burst-stop or precharge landing mid-burst at each latency, reads and writes cutting into each other, and zero- and one-beat lengths.

// File: rtl/sdram_dpath_timer.sv
module sdram_dpath_timer #(
  parameter int MASK_W = 2,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              term_cmd,
  input  logic              pre_cmd,
  input  logic [2:0]        cas_code,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [MASK_W-1:0] dqm_in,
  output logic              rd_valid,
  output logic [LEN_W-1:0]  rd_beat,
  output logic [MASK_W-1:0] rd_byte_en,
  output logic              bus_oe,
  output logic              wr_drive,
  output logic [LEN_W-1:0]  wr_beat,
  output logic [MASK_W-1:0] wr_byte_en,
  output logic [MASK_W-1:0] dqm_q
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam int DEPTH = 3;

  logic [LEN_W-1:0] left_init;
  logic             stop_now;
  logic [LEN_W-1:0] rd_left, rd_next;
  logic [LEN_W-1:0] wr_left, wr_next;
  logic             iss_v;
  logic [LEN_W-1:0] iss_idx;
  logic             wr_go, wr_cont;
  logic             lat3_q;
  logic [DEPTH:1]   pipe_v;
  logic [LEN_W-1:0] pipe_idx [1:DEPTH];
  logic [MASK_W-1:0] dqm_d2;

  assign left_init = (burst_len == '0) ? '0 : burst_len - ONE;
  assign stop_now  = term_cmd | pre_cmd;

  // read beat issue: new read restarts, write or stop ends the burst
  assign iss_v   = rd_cmd | ((rd_left != '0) & ~wr_cmd & ~stop_now);
  assign iss_idx = rd_cmd ? '0 : rd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_left <= '0;
      rd_next <= '0;
      lat3_q  <= 1'b1;
    end else if (rd_cmd) begin
      rd_left <= left_init;
      rd_next <= ONE;
      lat3_q  <= (cas_code != 3'b010);
    end else if (wr_cmd || stop_now) begin
      rd_left <= '0;
    end else if (rd_left != '0) begin
      rd_left <= rd_left - ONE;
      rd_next <= rd_next + ONE;
    end
  end

  // every issued beat rides the same delay line, so bursts never overlap
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_v <= '0;
      for (int i = 1; i <= DEPTH; i++) pipe_idx[i] <= '0;
    end else begin
      pipe_v      <= {pipe_v[DEPTH-1:1], iss_v};
      pipe_idx[1] <= iss_idx;
      for (int i = 2; i <= DEPTH; i++) pipe_idx[i] <= pipe_idx[i-1];
    end
  end

  assign rd_valid = lat3_q ? pipe_v[3] : pipe_v[2];
  assign rd_beat  = lat3_q ? pipe_idx[3] : pipe_idx[2];
  assign bus_oe   = lat3_q ? (pipe_v[2] | pipe_v[3]) : (pipe_v[1] | pipe_v[2]);

  // write path: zero delay from the command to the first data beat
  assign wr_go    = wr_cmd & ~rd_cmd;
  assign wr_cont  = (wr_left != '0) & ~rd_cmd & ~stop_now & ~wr_cmd;
  assign wr_drive = wr_go | wr_cont;
  assign wr_beat  = wr_go ? '0 : wr_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_left <= '0;
      wr_next <= '0;
    end else if (wr_go) begin
      wr_left <= left_init;
      wr_next <= ONE;
    end else if (wr_cont) begin
      wr_left <= wr_left - ONE;
      wr_next <= wr_next + ONE;
    end else begin
      wr_left <= '0;
    end
  end

  // masks: writes act at once, reads two clocks later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dqm_q  <= '0;
      dqm_d2 <= '0;
    end else begin
      dqm_q  <= dqm_in;
      dqm_d2 <= dqm_q;
    end
  end

  assign wr_byte_en = wr_drive ? ~dqm_in : '0;
  assign rd_byte_en = rd_valid ? ~dqm_d2 : '0;

  p_oe_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(bus_oe));

  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != '0) |-> ($past(rd_valid) && rd_beat == $past(rd_beat) + ONE));

  p_wr_zero_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !rd_cmd) |-> (wr_drive && wr_beat == '0));

  p_wr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drive && !wr_cmd) |-> ($past(wr_drive) && wr_beat == $past(wr_beat) + ONE));

  p_rd_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_byte_en == ~$past(dqm_q)));

  p_wr_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now && !rd_cmd && !wr_cmd) |-> !wr_drive);

  p_rd_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |-> !wr_drive);
endmodule

// File: tb/sdram_dpath_timer_tb.sv
module sdram_dpath_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 2;
  localparam int LW = 10;
  localparam int HN = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_cmd = 0, wr_cmd = 0, term_cmd = 0, pre_cmd = 0;
  logic [2:0] cas_code = 3'b010;
  logic [LW-1:0] burst_len = 4;
  logic [MW-1:0] dqm_in = '0;
  logic rd_valid, bus_oe, wr_drive;
  logic [LW-1:0] rd_beat, wr_beat;
  logic [MW-1:0] rd_byte_en, wr_byte_en, dqm_q;

  sdram_dpath_timer #(.MASK_W(MW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .term_cmd(term_cmd), .pre_cmd(pre_cmd), .cas_code(cas_code),
    .burst_len(burst_len), .dqm_in(dqm_in), .rd_valid(rd_valid),
    .rd_beat(rd_beat), .rd_byte_en(rd_byte_en), .bus_oe(bus_oe),
    .wr_drive(wr_drive), .wr_beat(wr_beat), .wr_byte_en(wr_byte_en),
    .dqm_q(dqm_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, t = 0;
  bit done = 0;
  bit exp_rv [HN];
  bit exp_oe [HN];
  int exp_ri [HN];
  logic [MW-1:0] dqm_h [HN];
  int m_rleft = 0, m_ridx = 0, m_lat = 3;
  int m_wleft = 0, m_widx = 0;

  task automatic chk(string tag, string nm, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual=%0d expected=%0d", tag, nm, t, act, expv);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input bit tm, input bit pr,
                     input logic [2:0] code, input int len, input logic [MW-1:0] dq);
    int eff;
    bit wd;
    int wb;
    logic [MW-1:0] e;
    @(posedge clk); #1;
    rd_cmd = rd; wr_cmd = wr; term_cmd = tm; pre_cmd = pr;
    cas_code = code; burst_len = LW'(len); dqm_in = dq;
    dqm_h[t] = dq;
    eff = (len == 0) ? 1 : len;
    // read issue model
    if (rd) begin
      m_lat = (code == 3'b010) ? 2 : 3;
      exp_rv[t+m_lat] = 1; exp_ri[t+m_lat] = 0;
      exp_oe[t+m_lat] = 1; exp_oe[t+m_lat-1] = 1;
      m_rleft = eff - 1; m_ridx = 1;
    end else if (m_rleft > 0 && !wr && !tm && !pr) begin
      exp_rv[t+m_lat] = 1; exp_ri[t+m_lat] = m_ridx;
      exp_oe[t+m_lat] = 1; exp_oe[t+m_lat-1] = 1;
      m_rleft--; m_ridx++;
    end else begin
      m_rleft = 0;
    end
    // write model
    wd = 0; wb = 0;
    if (rd) m_wleft = 0;
    else if (wr) begin wd = 1; wb = 0; m_wleft = eff - 1; m_widx = 1; end
    else if (m_wleft > 0 && !tm && !pr) begin wd = 1; wb = m_widx; m_wleft--; m_widx++; end
    else m_wleft = 0;
    @(negedge clk);
    chk("R1 R3 R7 R8 R9", "rd_valid", int'(rd_valid), int'(exp_rv[t]));
    if (exp_rv[t]) chk("R3 R8", "rd_beat", int'(rd_beat), exp_ri[t]);
    e = exp_rv[t] ? ~dqm_h[t-2] : '0;
    chk("R6", "rd_byte_en", int'(rd_byte_en), int'(e));
    chk("R2 R7", "bus_oe", int'(bus_oe), int'(exp_oe[t]));
    chk("R4 R7 R9", "wr_drive", int'(wr_drive), int'(wd));
    if (wd) chk("R4", "wr_beat", int'(wr_beat), wb);
    e = wd ? ~dq : '0;
    chk("R5", "wr_byte_en", int'(wr_byte_en), int'(e));
    e = (t >= 1) ? dqm_h[t-1] : '0;
    chk("R6", "dqm_q", int'(dqm_q), int'(e));
    t++;
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 3'b010, 4, MW'((t * 3) >> 1));
  endtask

  task automatic rd(logic [2:0] code, int len);
    cyc(1, 0, 0, 0, code, len, MW'(t));
  endtask

  task automatic wr(int len);
    cyc(0, 1, 0, 0, 3'b010, len, MW'(t + 1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < HN; i++) begin
      exp_rv[i] = 0; exp_oe[i] = 0; exp_ri[i] = 0; dqm_h[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs quiet in reset
    chk("R10", "reset rd_valid", int'(rd_valid), 0);
    chk("R10", "reset bus_oe", int'(bus_oe), 0);
    chk("R10", "reset wr_drive", int'(wr_drive), 0);
    chk("R10", "reset masks", int'({rd_byte_en, wr_byte_en, dqm_q}), 0);
    rst_n = 1'b1;
    nop(3);
    // R1 R2 R3: latency 2, burst of 4
    rd(3'b010, 4); nop(8);
    // R1 R6: latency 3, burst of 8 with changing masks
    rd(3'b011, 8); nop(12);
    // R1: reserved code behaves as latency 3
    rd(3'b111, 2); nop(6);
    // R4 R5: write burst of 4
    wr(4); nop(6);
    // R7: burst-stop mid read at latency 3
    rd(3'b011, 8); nop(2); cyc(0, 0, 1, 0, 3'b011, 8, 2'b01); nop(8);
    // R7: precharge mid read at latency 2
    rd(3'b010, 8); nop(3); cyc(0, 0, 0, 1, 3'b010, 8, 2'b10); nop(8);
    // R7: burst-stop mid write
    wr(8); nop(2); cyc(0, 0, 1, 0, 3'b010, 8, 2'b00); nop(4);
    // R8: reads one clock apart, both latencies
    rd(3'b010, 4); rd(3'b010, 4); nop(1); rd(3'b010, 4); nop(8);
    rd(3'b011, 8); nop(2); rd(3'b011, 2); rd(3'b011, 1); rd(3'b011, 1); nop(8);
    // R3: zero length means one beat
    rd(3'b010, 0); nop(4); wr(0); nop(3);
    // R9: write cuts a read, read cuts a write, read beats write
    rd(3'b011, 8); nop(2); wr(4); nop(8);
    wr(8); nop(2); rd(3'b010, 2); nop(6);
    cyc(1, 1, 0, 0, 3'b010, 4, 2'b11); nop(8);
    // R3: full-page length at latency 3
    rd(3'b011, 512); nop(520);
    // R8: read after full page, different latency once idle
    rd(3'b010, 8); nop(10);
    summary();
  end
endmodule